// File: doc/BRIEF.md
# Host Memory Access Port

This block gives an external host, running on its own clock, read and write access to a processor's on-chip memories. There are two memories: a 24-bit program store and a 16-bit data store. The host uses a 16-bit multiplexed address/data bus and four strobes: select, read, write and address latch. The port answers on an acknowledge line.

The host sends a start address once, together with a one-bit memory-type tag. After that it only strobes data. Each completed access moves the latched address forward by one word, so a whole block streams from a single address phase. The processor may also load the address register itself.

All host strobes are resynchronised into the processor clock. Each word then costs one synchronisation cycle and one access cycle. In the access cycle the port takes the memory and holds the core off for that single cycle. A 24-bit program word travels as two 16-bit host transfers. The top 32 data-memory locations are reserved for control registers, and the port never writes them.

Top module: `hmap_port`

## Requirements
- R1: On the falling edge of `host_ale_i`, the port latches `ad_i[13:0]` as the word address and `ad_i[14]` as the memory type (1 = program memory, 0 = data memory).
- R2: A transfer starts only on the rising edge of `host_sel_i & host_rd_i` or of `host_sel_i & host_wr_i`. A read or write strobe without select leaves `ack_o` high, memory unchanged and the address unchanged.
- R3: After a start is detected, `ack_o` stays low for exactly two core cycles: one synchronisation cycle, then one access cycle. It returns high when the access completes.
- R4: `stall_o` is high for exactly one cycle for each real memory access, and never for a transfer that touches no memory.
- R5: The address increments by one after every data-memory transfer, and after the second half of every program-memory word.
- R6: A program-memory write takes two transfers. The first carries bits 23:8 of the word. The second carries bits 7:0 in `ad_i[7:0]`. The memory is written only on the second transfer.
- R7: A program-memory read takes two transfers. The first returns bits 23:8. The second returns `{8'h00, bits 7:0}` and needs no memory cycle.
- R8: Data-memory writes at addresses 0x3FE0 and above are discarded.
- R9: `core_ld_i` loads `core_addr_i` and `core_type_i` into the address register and restarts the program-word half phase. In the same cycle it takes priority over an increment.
- R10: `ad_oe_o` equals `host_sel_i & host_rd_i`. While it is high, `ad_o` carries the word of the most recent completed read.
- R11: After reset, `ack_o` = 1, `stall_o` = 0, the address is 0 and the type is data memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_sel_i | input | 1 | Host select, asynchronous |
| host_rd_i | input | 1 | Host read strobe, asynchronous |
| host_wr_i | input | 1 | Host write strobe, asynchronous |
| host_ale_i | input | 1 | Host address-latch strobe, latched on its fall |
| ad_i | input | 16 | Multiplexed address/data from host |
| ad_o | output | 16 | Read data to host |
| ad_oe_o | output | 1 | Bus drive enable for `ad_o` |
| ack_o | output | 1 | High when the port can accept a strobe |
| core_ld_i | input | 1 | Core load of the address register |
| core_addr_i | input | 14 | Address loaded by the core |
| core_type_i | input | 1 | Memory type loaded by the core (1 = program) |
| stall_o | output | 1 | Holds the core off during a memory cycle |

## Verification
A core load of the address register can land in the same cycle as the auto-increment that ends a host access. The bench provokes this by watching for `stall_o` and raising `core_ld_i` in exactly that access cycle. It judges the outcome over the host bus. The interrupted write must sit at the old address. The next write must land at the core-loaded address rather than at old address plus one. Both results are read back and compared.

// File: rtl/hmap_pkg.sv
package hmap_pkg;
  typedef enum logic [1:0] {
    RSEL_DM    = 2'd0,
    RSEL_PM_HI = 2'd1,
    RSEL_PM_LO = 2'd2
  } rsel_e;
  localparam logic TYPE_PM = 1'b1;
endpackage

// File: rtl/hmap_sync.sv
module hmap_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= '0;
      else         ff <= {ff[0], d_i[g]};
    end
    assign q_o[g] = ff[1];
  end
endmodule

// File: rtl/hmap_ram.sv
module hmap_ram #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem[addr_i] <= wdata_i;
      else      rdata_q     <= mem[addr_i];
    end
  end
  assign rdata_o = rdata_q;
endmodule

// File: rtl/hmap_port.sv
module hmap_port
  import hmap_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned PM_W     = 24,
  parameter int unsigned MEM_AW   = 8,
  parameter int unsigned REG_BASE = 'h3FE0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_sel_i,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic              host_ale_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              ack_o,
  input  logic              core_ld_i,
  input  logic [ADDR_W-1:0] core_addr_i,
  input  logic              core_type_i,
  output logic              stall_o
);
  localparam int unsigned LO_W = PM_W - DATA_W;
  localparam logic [ADDR_W-1:0] REG_BASE_L = ADDR_W'(REG_BASE);

  // synchronised strobes: {ale, wr, rd, sel}
  logic [3:0] s;
  hmap_sync #(.W(4)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({host_ale_i, host_wr_i, host_rd_i, host_sel_i}),
    .q_o   (s)
  );

  logic rd_lvl, wr_lvl, ale_lvl;
  logic rd_lvl_q, wr_lvl_q, ale_q;
  logic rd_rise, wr_rise, ale_fall;
  assign rd_lvl  = s[0] & s[1];
  assign wr_lvl  = s[0] & s[2];
  assign ale_lvl = s[3];
  assign rd_rise  = rd_lvl & ~rd_lvl_q;
  assign wr_rise  = wr_lvl & ~wr_lvl_q;
  assign ale_fall = ~ale_lvl & ale_q;

  logic              pend_q, acc_q, acc_wr_q, pm_lo_q, type_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] pm_hi_q;
  rsel_e             rsel_q;

  logic busy, start, is_pm, mem_touch, reg_hit, step;
  logic dm_en, dm_we, dm_wr, pm_en;
  logic [DATA_W-1:0] dm_rdata;
  logic [PM_W-1:0]   pm_rdata, pm_wdata;

  assign busy      = pend_q | acc_q;
  assign start     = (rd_rise | wr_rise) & ~busy;
  assign is_pm     = (type_q == TYPE_PM);
  assign mem_touch = ~is_pm | (acc_wr_q ? pm_lo_q : ~pm_lo_q);
  assign reg_hit   = (addr_q >= REG_BASE_L);
  assign dm_en     = acc_q & ~is_pm & ~(acc_wr_q & reg_hit);
  assign dm_we     = acc_wr_q;
  assign dm_wr     = dm_en & dm_we;
  assign pm_en     = acc_q & is_pm & mem_touch;
  assign pm_wdata  = {pm_hi_q, ad_i[LO_W-1:0]};
  assign step      = acc_q & (~is_pm | pm_lo_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_lvl_q <= 1'b0;
      wr_lvl_q <= 1'b0;
      ale_q    <= 1'b0;
      pend_q   <= 1'b0;
      acc_q    <= 1'b0;
      acc_wr_q <= 1'b0;
      pm_lo_q  <= 1'b0;
      type_q   <= 1'b0;
      addr_q   <= '0;
      pm_hi_q  <= '0;
      rsel_q   <= RSEL_DM;
    end else begin
      rd_lvl_q <= rd_lvl;
      wr_lvl_q <= wr_lvl;
      ale_q    <= ale_lvl;
      pend_q   <= start;
      acc_q    <= pend_q;
      if (start) acc_wr_q <= wr_rise;
      if (acc_q) begin
        if (is_pm) pm_lo_q <= ~pm_lo_q;
        if (is_pm && acc_wr_q && !pm_lo_q) pm_hi_q <= ad_i;
        if (!acc_wr_q)
          rsel_q <= !is_pm ? RSEL_DM : (pm_lo_q ? RSEL_PM_LO : RSEL_PM_HI);
      end
      // core load wins over host latch and increment
      if (core_ld_i) begin
        addr_q  <= core_addr_i;
        type_q  <= core_type_i;
        pm_lo_q <= 1'b0;
      end else if (ale_fall) begin
        addr_q  <= ad_i[ADDR_W-1:0];
        type_q  <= ad_i[ADDR_W];
        pm_lo_q <= 1'b0;
      end else if (step) begin
        addr_q  <= addr_q + 1'b1;
      end
    end
  end

  hmap_ram #(.W(DATA_W), .AW(MEM_AW)) u_dm (
    .clk_i  (clk_i),
    .en_i   (dm_en),
    .we_i   (dm_we),
    .addr_i (addr_q[MEM_AW-1:0]),
    .wdata_i(ad_i),
    .rdata_o(dm_rdata)
  );

  hmap_ram #(.W(PM_W), .AW(MEM_AW)) u_pm (
    .clk_i  (clk_i),
    .en_i   (pm_en),
    .we_i   (acc_wr_q),
    .addr_i (addr_q[MEM_AW-1:0]),
    .wdata_i(pm_wdata),
    .rdata_o(pm_rdata)
  );

  always_comb begin
    unique case (rsel_q)
      RSEL_PM_HI: ad_o = pm_rdata[PM_W-1:LO_W];
      RSEL_PM_LO: ad_o = {{(DATA_W-LO_W){1'b0}}, pm_rdata[LO_W-1:0]};
      default:    ad_o = dm_rdata;
    endcase
  end

  assign ad_oe_o = host_sel_i & host_rd_i;
  assign ack_o   = ~busy;
  assign stall_o = acc_q & mem_touch;
endmodule

// File: rtl/hmap_port_chk.sv
module hmap_port_chk #(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned REG_BASE = 'h3FE0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_o,
  input logic              stall_o,
  input logic              step_i,
  input logic              ale_fall_i,
  input logic              core_ld_i,
  input logic [ADDR_W-1:0] core_addr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              dm_wr_i
);
  localparam logic [ADDR_W-1:0] REG_BASE_L = ADDR_W'(REG_BASE);

  assert_stall_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);

  assert_ack_low_access_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !ack_o);

  assert_sync_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> $past(!ack_o));

  assert_no_reg_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_wr_i |-> (addr_i < REG_BASE_L));

  assert_auto_incr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !core_ld_i && !ale_fall_i) |=> (addr_i == $past(addr_i) + 1'b1));

  assert_core_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_ld_i |=> (addr_i == $past(core_addr_i)));
endmodule

bind hmap_port hmap_port_chk #(.ADDR_W(ADDR_W), .REG_BASE(REG_BASE)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_o      (ack_o),
  .stall_o    (stall_o),
  .step_i     (step),
  .ale_fall_i (ale_fall),
  .core_ld_i  (core_ld_i),
  .core_addr_i(core_addr_i),
  .addr_i     (addr_q),
  .dm_wr_i    (dm_wr)
);

// File: tb/hmap_port_tb.sv
`timescale 1ns/1ps
module hmap_port_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_sel_i = 1'b0, host_rd_i = 1'b0, host_wr_i = 1'b0, host_ale_i = 1'b0;
  logic [15:0] ad_i = '0;
  logic [15:0] ad_o;
  logic        ad_oe_o, ack_o, stall_o;
  logic        core_ld_i = 1'b0;
  logic [13:0] core_addr_i = '0;
  logic        core_type_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit rd_active = 0;
  logic ack_prev = 1'b1;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk_i = ~clk_i;

  hmap_port dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .host_sel_i(host_sel_i), .host_rd_i(host_rd_i), .host_wr_i(host_wr_i),
    .host_ale_i(host_ale_i), .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .ack_o(ack_o), .core_ld_i(core_ld_i), .core_addr_i(core_addr_i),
    .core_type_i(core_type_i), .stall_o(stall_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      summary();
    end
  end

  // monitor: compare read data when ack returns during a read
  always @(negedge clk_i) begin
    if (rd_active && ack_o && !ack_prev) begin
      if (exp_q.size() == 0) begin
        chk(0, "scoreboard-empty", 0, 0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(ad_o == e, t, ad_o, e);
      end
    end
    ack_prev = ack_o;
  end

  task automatic ale(input bit pm, input logic [13:0] a);
    @(negedge clk_i);
    ad_i = {1'b0, pm, a};
    host_ale_i = 1'b1;
    repeat (4) @(negedge clk_i);
    host_ale_i = 1'b0;
    repeat (5) @(negedge clk_i);
  endtask

  task automatic core_load(input bit pm, input logic [13:0] a);
    @(negedge clk_i);
    core_ld_i = 1'b1; core_addr_i = a; core_type_i = pm;
    @(negedge clk_i);
    core_ld_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic xfer(input bit rd, input logic [15:0] wd, input logic [15:0] exp,
                      input int exp_stall, input string tag,
                      input bit conc = 0, input logic [13:0] ld_a = '0);
    int low, st;
    low = 0; st = 0;
    @(negedge clk_i);
    if (rd) begin
      exp_q.push_back(exp); tag_q.push_back(tag);
      rd_active = 1; host_rd_i = 1'b1;
    end else begin
      ad_i = wd; host_wr_i = 1'b1;
    end
    host_sel_i = 1'b1;
    #1;
    if (rd) chk(ad_oe_o == 1'b1, "R10 oe-high", ad_oe_o, 1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      core_ld_i = 1'b0;
      if (!ack_o) low++;
      if (stall_o) begin
        st++;
        if (conc) begin
          core_ld_i = 1'b1; core_addr_i = ld_a; core_type_i = 1'b0;
        end
      end
      if (low > 0 && ack_o) break;
    end
    core_ld_i = 1'b0;
    chk(low == 2, {"R3 ack-low ", tag}, low, 2);
    chk(st == exp_stall, {"R4 stall ", tag}, st, exp_stall);
    host_sel_i = 1'b0; host_rd_i = 1'b0; host_wr_i = 1'b0;
    #1;
    if (rd) chk(ad_oe_o == 1'b0, "R10 oe-low", ad_oe_o, 0);
    repeat (4) @(negedge clk_i);
    rd_active = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(ack_o == 1'b1, "R11 ack", ack_o, 1);
    chk(stall_o == 1'b0, "R11 stall", stall_o, 0);
    chk(ad_oe_o == 1'b0, "R10 oe idle", ad_oe_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R11: write with no address phase goes to data word 0
    xfer(0, 16'h1234, '0, 1, "R11 wr");
    ale(0, 14'h0000);
    xfer(1, '0, 16'h1234, 1, "R11 rd addr0");

    // R1/R5: data block streaming
    ale(0, 14'h0010);
    xfer(0, 16'hA001, '0, 1, "R5 wr0");
    xfer(0, 16'hB002, '0, 1, "R5 wr1");
    xfer(0, 16'hC003, '0, 1, "R5 wr2");
    ale(0, 14'h0010);
    xfer(1, '0, 16'hA001, 1, "R1 rd0");
    xfer(1, '0, 16'hB002, 1, "R5 rd1");
    xfer(1, '0, 16'hC003, 1, "R5 rd2");

    // R6/R7: program words in two halves
    ale(1, 14'h0005);
    xfer(0, 16'hABCD, '0, 0, "R6 hi0");
    xfer(0, 16'h00EF, '0, 1, "R6 lo0");
    xfer(0, 16'h1357, '0, 0, "R6 hi1");
    xfer(0, 16'h0024, '0, 1, "R6 lo1");
    ale(0, 14'h0005);
    xfer(0, 16'h5555, '0, 1, "R1 dm5");
    ale(1, 14'h0005);
    xfer(1, '0, 16'hABCD, 1, "R7 hi0");
    xfer(1, '0, 16'h00EF, 0, "R7 lo0");
    xfer(1, '0, 16'h1357, 1, "R7 hi1");
    xfer(1, '0, 16'h0024, 0, "R7 lo1");
    ale(0, 14'h0005);
    xfer(1, '0, 16'h5555, 1, "R1 type dm5");

    // R8: reserved region not written
    ale(0, 14'h00E0);
    xfer(0, 16'h7777, '0, 1, "R8 base");
    ale(0, 14'h3FDF);
    xfer(0, 16'h4444, '0, 1, "R8 below");
    xfer(0, 16'h9999, '0, 1, "R8 blocked");
    ale(0, 14'h00DF);
    xfer(1, '0, 16'h4444, 1, "R8 rd below");
    xfer(1, '0, 16'h7777, 1, "R8 rd alias");

    // R2: write strobe without select
    ale(0, 14'h0030);
    xfer(0, 16'h0A0A, '0, 1, "R2 setup");
    ale(0, 14'h0030);
    begin
      int low, st;
      low = 0; st = 0;
      @(negedge clk_i);
      ad_i = 16'hFFFF; host_wr_i = 1'b1;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk_i);
        if (!ack_o) low++;
        if (stall_o) st++;
      end
      chk(low == 0, "R2 ack", low, 0);
      chk(st == 0, "R2 stall", st, 0);
      host_wr_i = 1'b0;
      repeat (4) @(negedge clk_i);
    end
    xfer(1, '0, 16'h0A0A, 1, "R2 unchanged");

    // R9: core load and half-phase restart
    core_load(0, 14'h0011);
    xfer(1, '0, 16'hB002, 1, "R9 load dm");
    ale(1, 14'h0005);
    xfer(1, '0, 16'hABCD, 1, "R9 pre hi");
    core_load(1, 14'h0005);
    xfer(1, '0, 16'hABCD, 1, "R9 phase restart");

    // R9: core load in the same cycle as the increment
    ale(0, 14'h0040);
    xfer(0, 16'h1111, '0, 1, "R9 conc wr", 1, 14'h0050);
    xfer(0, 16'h2222, '0, 1, "R9 after load");
    ale(0, 14'h0040);
    xfer(1, '0, 16'h1111, 1, "R9 old addr");
    ale(0, 14'h0050);
    xfer(1, '0, 16'h2222, 1, "R9 loaded addr");

    repeat (4) @(negedge clk_i);
    chk(exp_q.size() == 0, "scoreboard-drain", exp_q.size(), 0);
    summary();
  end
endmodule